// File: doc/BRIEF.md
# Min/max peak-detect decimator

This block thins a stream of narrow samples down to one peak pair per save interval. Every accepted sample is compared against a running minimum and a running maximum. When the interval closes, both extremes leave together as one double-width word on an acquisition-memory write port. The port has a data word, a single-cycle write strobe and a wrapping address counter. Narrow glitches therefore survive decimation even when thousands of samples fold into a single stored pair.

The interval length is programmable, counted in accepted samples. A slower timebase sets a longer interval, so more samples are folded into each stored pair. The block also keeps the kind of the last new extreme seen in the interval, either a new high or a new low. When swapping is enabled, it uses that flag to choose the byte order of the stored word, so the time order of the two peaks can be recovered from memory.

Top module: `pkdet_decim`

## Requirements
- R1: While `rst_n` is low, `wr_en` is 0, `wr_addr` is 0 and `wr_data` is 0.
- R2: With `intv_len` = L, each interval takes exactly L+1 accepted samples. `wr_en` is high for the single cycle that follows the clock edge that accepted the interval's last sample. `intv_len` is captured when the interval's first sample is accepted, and later changes to it do not affect the interval in progress.
- R3: The written word holds the smallest and the largest of all samples of the interval, the first and the last included. Every interval starts afresh from its own first sample.
- R4: With `swap_en` low on the last sample, the word is {max in bits [2*DATA_W-1:DATA_W], min in bits [DATA_W-1:0]}.
- R5: With `swap_en` high on the last sample, the word is {min, max} if the last new extreme of the interval was a new minimum. It is {max, min} if that extreme was a new maximum, or if no new extreme occurred after the first sample.
- R6: A sample equal to the current maximum or minimum raises no event and leaves the last-extreme flag unchanged.
- R7: `wr_addr` during a write pulse is the address being written. It advances by one in the cycle after each write and wraps from DEPTH-1 to 0. It never reaches DEPTH.
- R8: Cycles with `smp_valid` low are ignored. The bus value in those cycles changes neither the extremes nor the interval count, and it produces no write.
- R9: `wr_data` holds its value in every cycle in which `wr_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| smp_valid | input | 1 | Conversion tick: a sample is present this cycle |
| smp_data | input | DATA_W | Sample value, unsigned |
| intv_len | input | LEN_W | Interval length minus one, in samples |
| swap_en | input | 1 | Enables time-ordered byte swapping of the output word |
| wr_data | output | 2*DATA_W | Peak pair word for acquisition memory |
| wr_en | output | 1 | Single-cycle memory write strobe |
| wr_addr | output | clog2(DEPTH) | Write address, wraps at DEPTH |

## Verification
The bench builds the block with 4-bit samples, a 3-bit length field and a memory depth of 5. The narrow samples make exhaustive sweeps affordable. Every three-sample interval is run with swapping on, which covers all equal-value and new-extreme orderings. Every two-sample interval is run with swapping off. The depth is not a power of two, so the compare-based wrap path is used and wraps hundreds of times. Every interval length from one to eight samples is also run, with and without idle gaps between samples.

// File: rtl/pkdet_pkg.sv
package pkdet_pkg;

  // Kind of the most recent new extreme within an interval.
  typedef enum logic {
    EXT_HIGH = 1'b0,
    EXT_LOW  = 1'b1
  } ext_kind_e;

endpackage

// File: rtl/pkdet_seq.sv
// Interval sequencer: counts accepted samples and flags the first and the
// last sample of each save interval. Length is captured at the first sample.
module pkdet_seq #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_valid,
  input  logic [LEN_W-1:0] intv_len,
  output logic             first_o,
  output logic             last_o
);

  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic [LEN_W-1:0] len_eff;
  logic             first;
  logic             last;

  always_comb begin
    first   = (cnt_q == '0);
    len_eff = first ? intv_len : len_q;
    last    = smp_valid && (cnt_q == len_eff);
    cnt_d   = cnt_q;
    len_d   = len_q;
    if (smp_valid) begin
      if (first) begin
        len_d = intv_len;
      end
      if (last) begin
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      len_q <= '0;
    end else if (smp_valid) begin
      cnt_q <= cnt_d;
      len_q <= len_d;
    end
  end

  assign first_o = first;
  assign last_o  = last;

endmodule

// File: rtl/pkdet_track.sv
// Running extreme tracker. Presents the post-sample extremes and event flag
// combinationally so the closing sample folds in without an extra stage.
module pkdet_track
  import pkdet_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic              first,
  input  logic [DATA_W-1:0] smp_data,
  output logic [DATA_W-1:0] lo_nx,
  output logic [DATA_W-1:0] hi_nx,
  output ext_kind_e         kind_nx
);

  logic [DATA_W-1:0] lo_q;
  logic [DATA_W-1:0] hi_q;
  ext_kind_e         kind_q;
  logic              above;
  logic              below;

  always_comb begin
    above   = smp_data > hi_q;
    below   = smp_data < lo_q;
    lo_nx   = lo_q;
    hi_nx   = hi_q;
    kind_nx = kind_q;
    if (first) begin
      lo_nx   = smp_data;
      hi_nx   = smp_data;
      kind_nx = EXT_HIGH;
    end else if (above) begin
      hi_nx   = smp_data;
      kind_nx = EXT_HIGH;
    end else if (below) begin
      lo_nx   = smp_data;
      kind_nx = EXT_LOW;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q   <= '0;
      hi_q   <= '0;
      kind_q <= EXT_HIGH;
    end else if (smp_valid) begin
      lo_q   <= lo_nx;
      hi_q   <= hi_nx;
      kind_q <= kind_nx;
    end
  end

endmodule

// File: rtl/pkdet_wr.sv
// Write stage: orders the pair, registers the word and strobe, and keeps the
// wrapping memory address.
module pkdet_wr
  import pkdet_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 1024,
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int WORD_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic              swap_en,
  input  logic [DATA_W-1:0] lo_in,
  input  logic [DATA_W-1:0] hi_in,
  input  ext_kind_e         kind_in,
  output logic [WORD_W-1:0] wr_data,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr
);

  logic [WORD_W-1:0] data_q, data_d;
  logic              en_q;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [ADDR_W-1:0] addr_inc;

  always_comb begin
    if (swap_en && (kind_in == EXT_LOW)) begin
      data_d = {lo_in, hi_in};
    end else begin
      data_d = {hi_in, lo_in};
    end
  end

  generate
    if ((1 << ADDR_W) == DEPTH) begin : g_wrap_pow2
      always_comb addr_inc = addr_q + 1'b1;
    end else begin : g_wrap_cmp
      always_comb begin
        if (addr_q == ADDR_W'(DEPTH - 1)) begin
          addr_inc = '0;
        end else begin
          addr_inc = addr_q + 1'b1;
        end
      end
    end
  endgenerate

  always_comb begin
    addr_d = en_q ? addr_inc : addr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      en_q   <= 1'b0;
      addr_q <= '0;
    end else begin
      en_q   <= commit;
      addr_q <= addr_d;
      if (commit) begin
        data_q <= data_d;
      end
    end
  end

  assign wr_data = data_q;
  assign wr_en   = en_q;
  assign wr_addr = addr_q;

endmodule

// File: rtl/pkdet_decim.sv
module pkdet_decim
  import pkdet_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LEN_W  = 8,
  parameter int DEPTH  = 1024,
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int WORD_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_data,
  input  logic [LEN_W-1:0]  intv_len,
  input  logic              swap_en,
  output logic [WORD_W-1:0] wr_data,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr
);

  logic              first;
  logic              last;
  logic [DATA_W-1:0] lo_nx;
  logic [DATA_W-1:0] hi_nx;
  ext_kind_e         kind_nx;

  pkdet_seq #(.LEN_W(LEN_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp_valid(smp_valid),
    .intv_len (intv_len),
    .first_o  (first),
    .last_o   (last)
  );

  pkdet_track #(.DATA_W(DATA_W)) u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp_valid(smp_valid),
    .first    (first),
    .smp_data (smp_data),
    .lo_nx    (lo_nx),
    .hi_nx    (hi_nx),
    .kind_nx  (kind_nx)
  );

  pkdet_wr #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_wr (
    .clk    (clk),
    .rst_n  (rst_n),
    .commit (last),
    .swap_en(swap_en),
    .lo_in  (lo_nx),
    .hi_in  (hi_nx),
    .kind_in(kind_nx),
    .wr_data(wr_data),
    .wr_en  (wr_en),
    .wr_addr(wr_addr)
  );

endmodule

// File: rtl/pkdet_decim_chk.sv
module pkdet_decim_chk #(
  parameter int DATA_W = 8,
  parameter int LEN_W  = 8,
  parameter int DEPTH  = 1024,
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int WORD_W = 2 * DATA_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              smp_valid,
  input logic [DATA_W-1:0] smp_data,
  input logic [LEN_W-1:0]  intv_len,
  input logic              swap_en,
  input logic [WORD_W-1:0] wr_data,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr
);

  logic [ADDR_W-1:0] last_addr;
  assign last_addr = ADDR_W'(DEPTH - 1);

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_idle_R1: assert (!wr_en && (wr_addr == '0) && (wr_data == '0))
        else $error("reset state violated");
    end
  end

  assert_write_needs_sample_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(smp_valid))
    else $error("write without an accepted sample");

  assert_noswap_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !$past(swap_en)) |-> (wr_data[WORD_W-1:DATA_W] >= wr_data[DATA_W-1:0]))
    else $error("unswapped word not max-first");

  assert_addr_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (wr_addr == (($past(wr_addr) == last_addr) ? '0 : $past(wr_addr) + 1'b1)))
    else $error("address did not advance after write");

  assert_addr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(wr_addr))
    else $error("address moved without write");

  assert_addr_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_addr <= last_addr)
    else $error("address out of range");

  assert_data_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> $stable(wr_data))
    else $error("data changed without write");

endmodule

bind pkdet_decim pkdet_decim_chk #(
  .DATA_W(DATA_W),
  .LEN_W (LEN_W),
  .DEPTH (DEPTH)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .smp_valid(smp_valid),
  .smp_data (smp_data),
  .intv_len (intv_len),
  .swap_en  (swap_en),
  .wr_data  (wr_data),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr)
);

// File: tb/sim_pkdet_decim.sv
`timescale 1ns/1ps
module sim_pkdet_decim;

  localparam int DW = 4;
  localparam int LW = 3;
  localparam int DP = 5;
  localparam int AW = $clog2(DP);

  logic          clk;
  logic          rst_n;
  logic          smp_valid;
  logic [DW-1:0] smp_data;
  logic [LW-1:0] intv_len;
  logic          swap_en;
  logic [2*DW-1:0] wr_data;
  logic          wr_en;
  logic [AW-1:0] wr_addr;

  pkdet_decim #(.DATA_W(DW), .LEN_W(LW), .DEPTH(DP)) u0 (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .intv_len(intv_len), .swap_en(swap_en),
    .wr_data(wr_data), .wr_en(wr_en), .wr_addr(wr_addr)
  );

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  int exp_addr = 0;
  bit run = 0;
  bit done = 0;
  string cur_tag = "R3";

  logic [2*DW-1:0] exp_q[$];
  int              due_q[$];
  string           tag_q[$];

  initial clk = 1'b0;
  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic chk(input string tag, input bit ok, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // Write monitor: every pulse must match the oldest pending expectation.
  always @(negedge clk) begin
    if (run && rst_n) begin
      if (wr_en) begin
        if (exp_q.size() == 0) begin
          chk("R2 unexpected write", 1'b0, 1, 0);
        end else begin
          chk({tag_q[0], " word"}, wr_data == exp_q[0], int'(wr_data), int'(exp_q[0]));
          chk("R2 write cycle", due_q[0] == cyc, cyc, due_q[0]);
          chk("R7 address", int'(wr_addr) == exp_addr, int'(wr_addr), exp_addr);
          exp_addr = (exp_addr + 1) % DP;
          void'(exp_q.pop_front());
          void'(due_q.pop_front());
          void'(tag_q.pop_front());
        end
      end else if (exp_q.size() != 0 && due_q[0] <= cyc) begin
        chk("R2 missing write", 1'b0, 0, 1);
        void'(exp_q.pop_front());
        void'(due_q.pop_front());
        void'(tag_q.pop_front());
      end
    end
  end

  function automatic logic [2*DW-1:0] peak_word(input int s[8], input int n, input bit sw);
    int mn = s[0];
    int mx = s[0];
    bit low_last = 0;
    for (int i = 1; i < n; i++) begin
      if (s[i] > mx) begin mx = s[i]; low_last = 0; end
      else if (s[i] < mn) begin mn = s[i]; low_last = 1; end
    end
    if (sw && low_last) return {DW'(mn), DW'(mx)};
    return {DW'(mx), DW'(mn)};
  endfunction

  task automatic expect_now(input logic [2*DW-1:0] w);
    exp_q.push_back(w);
    due_q.push_back(cyc + 1);
    tag_q.push_back(cur_tag);
  endtask

  task automatic run_interval(input int s[8], input int n, input bit sw, input bit gaps);
    swap_en  = sw;
    intv_len = LW'(n - 1);
    for (int i = 0; i < n; i++) begin
      smp_valid = 1'b1;
      smp_data  = DW'(s[i]);
      if (i == n - 1) expect_now(peak_word(s, n, sw));
      @(negedge clk);
      if (gaps) begin
        smp_valid = 1'b0;
        smp_data  = ~DW'(s[i]);
        @(negedge clk);
      end
    end
    smp_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    smp_valid = 1'b0;
    for (int i = 0; i < n; i++) begin
      smp_data = DW'(i * 5);
      @(negedge clk);
    end
  endtask

  initial begin
    #(5.0 * 190000);
    chk("watchdog", 1'b0, cyc, 0);
    finish_up();
  end

  initial begin
    int s[8];
    logic [2*DW-1:0] held;
    rst_n = 1'b0; smp_valid = 1'b0; smp_data = '0; intv_len = '0; swap_en = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 wr_en", wr_en == 1'b0, int'(wr_en), 0);
    chk("R1 wr_addr", wr_addr == '0, int'(wr_addr), 0);
    chk("R1 wr_data", wr_data == '0, int'(wr_data), 0);
    rst_n = 1'b1;
    run = 1;
    @(negedge clk);

    // R6: equal values keep the flag.
    cur_tag = "R6";
    s = '{5, 9, 2, 9, 0, 0, 0, 0};
    run_interval(s, 4, 1'b1, 1'b0);
    s = '{5, 2, 9, 2, 0, 0, 0, 0};
    run_interval(s, 4, 1'b1, 1'b0);
    s = '{7, 7, 7, 0, 0, 0, 0, 0};
    run_interval(s, 3, 1'b1, 1'b0);
    idle(3);

    // R9: data holds while idle.
    held = wr_data;
    for (int i = 0; i < 4; i++) begin
      chk("R9 data hold", wr_data == held, int'(wr_data), int'(held));
      chk("R9 no strobe", wr_en == 1'b0, int'(wr_en), 0);
      @(negedge clk);
    end

    // R2: length captured at the first sample.
    cur_tag = "R2";
    swap_en = 1'b1; intv_len = 3'd3;
    smp_valid = 1'b1; smp_data = 4'd3; @(negedge clk);
    intv_len = 3'd0;
    smp_data = 4'd1; @(negedge clk);
    smp_data = 4'd7; @(negedge clk);
    smp_data = 4'd4; expect_now(8'h71); @(negedge clk);
    smp_valid = 1'b0;
    idle(2);

    // R8: invalid cycles ignored, including inside an interval.
    cur_tag = "R8";
    idle(10);
    chk("R8 queue drained", exp_q.size() == 0, exp_q.size(), 0);
    swap_en = 1'b0; intv_len = 3'd1;
    smp_valid = 1'b1; smp_data = 4'd5; @(negedge clk);
    smp_valid = 1'b0; smp_data = 4'd0; @(negedge clk);
    smp_data = 4'd15; @(negedge clk);
    smp_valid = 1'b1; smp_data = 4'd6; expect_now(8'h65); @(negedge clk);
    smp_valid = 1'b0;
    idle(3);

    // R5: every three-sample interval, swapping on.
    cur_tag = "R5";
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        for (int c = 0; c < 16; c++) begin
          s = '{a, b, c, 0, 0, 0, 0, 0};
          run_interval(s, 3, 1'b1, 1'b0);
        end
    idle(2);

    // R4: every two-sample interval, swapping off.
    cur_tag = "R4";
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++) begin
        s = '{a, b, 0, 0, 0, 0, 0, 0};
        run_interval(s, 2, 1'b0, 1'b0);
      end
    idle(2);

    // R3: all lengths, with gaps and both swap settings.
    cur_tag = "R3";
    for (int l = 0; l < 8; l++)
      for (int k = 0; k < 3; k++) begin
        for (int i = 0; i < 8; i++) s[i] = (i * 7 + k * 5 + l * 3) % 16;
        run_interval(s, l + 1, k == 2, k == 1);
      end
    idle(4);
    chk("R2 all writes seen", exp_q.size() == 0, exp_q.size(), 0);
    finish_up();
  end

endmodule